// File: doc/BRIEF.md
# Asynchronous Schedule Fetch Controller

This block sits in front of the asynchronous-list DMA engine of a USB host controller. It decides whether the engine may read memory at all, and which descriptor it asks for next. For each transaction it walks through three structures in turn: the queue head, then its transfer descriptor, then the outbound payload. Each read request carries its structure type and its length in dwords. A two-entry transaction buffer lets the reads for the next transaction start while the current one is still on the ports.

The controller also handles three special cases:
- **Empty schedule.** When the list head is reached and no transaction has completed since the last pass, the engine goes to sleep for a fixed 10 µs interval.
- **Ping state.** A queue head in the Ping state gets no payload read. A positive acknowledgement to its Ping asks for the queue head to be written back in the Out state.
- **Late start.** A packet that cannot finish before the microframe ends stops all port activity until the next microframe starts.

Reads from a separate periodic engine are not seen here, so they never hold this block back.

Top module: `async_fetch_ctrl`

## Requirements
- R1: `fetchReq` is high only while all four gates hold: `hcHalted` low, `asyncSchedOn` high, `busMasterEn` high and `sleeping` low. Removing any gate withdraws a request that has not been granted in the same cycle.
- R2: When a queue head is decoded with `qhHeadBit` set and the reclamation flag clear, the engine enters sleep and issues no descriptor read. When the flag is set, traversal continues and the flag is cleared.
- R3: `sleeping` stays high for SLEEP_CYCLES clock cycles (10 µs at the configured clock, 2500 cycles at 250 MHz). After that, a queue-head read is requested again.
- R4: Every completion handshake (`hsValid`) sets the reclamation flag.
- R5: The buffer holds DEPTH (2) transactions. A transaction takes an entry when its queue head is decoded without sleeping, and frees it on `hsValid`. No queue-head read is requested while all entries are taken.
- R6: A queue head decoded with `qhPing` set gets a descriptor read but no payload read.
- R7: `hsValid` with `hsPing` and `hsAck` both high makes `qhWbToOut` pulse high for exactly the following cycle. Otherwise `qhWbToOut` stays low.
- R8: A `txStart` with `txLen` greater than `uframeLeft` raises `portStop` from the next cycle. `portStop` stays high until the cycle after `uframeTick`. A packet that fits leaves `portStop` unchanged.
- R9: Read lengths are:
  - 17 for a queue head;
  - 13 for a transfer descriptor;
  - `qhDataLen` clamped to 129 for payload.
  A zero `qhDataLen` skips the payload read.
- R10: Reads of one transaction follow the order queue head, descriptor, payload. `fetchType` encodes them as 0 = queue head, 1 = descriptor, 2 = payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hcHalted | input | 1 | Controller halted status |
| asyncSchedOn | input | 1 | Asynchronous schedule status |
| busMasterEn | input | 1 | Bus mastering permitted |
| qhValid | input | 1 | A fetched queue head has been decoded this cycle |
| qhHeadBit | input | 1 | Decoded queue head marks the list head |
| qhPing | input | 1 | Decoded queue head is in the Ping state |
| qhDataLen | input | 8 | Payload length of the decoded queue head, dwords |
| fetchGrant | input | 1 | Memory side accepts the current request |
| fetchReq | output | 1 | Read request |
| fetchType | output | 2 | Structure being read (0 QH, 1 descriptor, 2 payload) |
| fetchLen | output | 8 | Read length in dwords |
| hsValid | input | 1 | A transaction's completion handshake arrived |
| hsPing | input | 1 | That transaction was a Ping |
| hsAck | input | 1 | That handshake was an acknowledgement |
| qhWbToOut | output | 1 | Write the queue head back in the Out state |
| txStart | input | 1 | A packet is about to go on the wire |
| txLen | input | 16 | Time the packet needs |
| uframeLeft | input | 16 | Time left in the microframe |
| uframeTick | input | 1 | A new microframe begins |
| portStop | output | 1 | Port activity halted for the rest of the microframe |
| sleeping | output | 1 | Engine is in its empty-schedule sleep |

## Verification
The following properties are checked on every cycle:
- no request ever escapes the four gates;
- the buffer count never exceeds its depth, and no queue-head read is issued while it is full;
- every length matches its structure type;
- the Ping write-back pulse and the set and clear of the port stop follow their triggers by one cycle.

The following can only be shown by the bench's scenarios:
- the read sequence of whole transactions, including the dropped payload for Ping and zero-length queue heads;
- the choice between sleeping and continuing at the list head, which depends on the hidden reclamation flag;
- the length of the sleep measured against the 10 µs tolerance window.

// File: rtl/afc_pkg.sv
package afc_pkg;
  typedef enum logic [1:0] {
    FT_QH   = 2'd0,
    FT_QTD  = 2'd1,
    FT_DATA = 2'd2
  } fetch_t;

  typedef enum logic [2:0] {
    ST_QH,
    ST_WAITQH,
    ST_QTD,
    ST_DATA,
    ST_SLEEP
  } walk_t;

  // strobes from control to datapath
  typedef struct packed {
    logic commitTxn;   // transaction takes a buffer entry, latch QH fields
    logic startSleep;  // load the sleep timer
    logic passHead;    // list head passed: clear reclamation
  } ctrlStrb_t;

  localparam int unsigned QH_DW  = 17;
  localparam int unsigned QTD_DW = 13;
endpackage

// File: rtl/afc_ctrl.sv
module afc_ctrl
  import afc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      gateOk,
  input  logic      bufFull,
  input  logic      sleepDone,
  input  logic      reclaim,
  input  logic      curPing,
  input  logic      curLenZero,
  input  logic      qhValid,
  input  logic      qhHeadBit,
  input  logic      fetchGrant,
  output logic      fetchReq,
  output fetch_t    fetchType,
  output logic      sleeping,
  output ctrlStrb_t strb
);

  walk_t state, stateNxt;
  logic  wantFetch;

  assign sleeping = (state == ST_SLEEP);

  always_comb begin
    stateNxt  = state;
    strb      = '0;
    fetchType = FT_QH;
    wantFetch = 1'b0;
    case (state)
      ST_QH: begin
        fetchType = FT_QH;
        wantFetch = !bufFull;
      end
      ST_QTD: begin
        fetchType = FT_QTD;
        wantFetch = 1'b1;
      end
      ST_DATA: begin
        fetchType = FT_DATA;
        wantFetch = 1'b1;
      end
      default: ;
    endcase
    fetchReq = wantFetch && gateOk && !sleeping;

    case (state)
      ST_QH:     if (fetchReq && fetchGrant) stateNxt = ST_WAITQH;
      ST_WAITQH: if (qhValid) begin
        strb.passHead = qhHeadBit;
        if (qhHeadBit && !reclaim) begin
          strb.startSleep = 1'b1;
          stateNxt        = ST_SLEEP;
        end else begin
          strb.commitTxn = 1'b1;
          stateNxt       = ST_QTD;
        end
      end
      ST_QTD: if (fetchReq && fetchGrant)
        stateNxt = (!curPing && !curLenZero) ? ST_DATA : ST_QH;
      ST_DATA:  if (fetchReq && fetchGrant) stateNxt = ST_QH;
      ST_SLEEP: if (sleepDone) stateNxt = ST_QH;
      default:  stateNxt = ST_QH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_QH;
    else       state <= stateNxt;
  end

endmodule

// File: rtl/afc_dpath.sv
module afc_dpath
  import afc_pkg::*;
#(
  parameter int unsigned DEPTH        = 2,
  parameter int unsigned SLEEP_CYCLES = 2500,
  parameter int unsigned LEN_W        = 8,
  parameter int unsigned TIME_W       = 16,
  parameter int unsigned MAX_DATA_DW  = 129,
  localparam int unsigned CNT_W       = $clog2(DEPTH + 1),
  localparam int unsigned SLP_W       = $clog2(SLEEP_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic              sleeping,
  input  fetch_t            fetchType,
  input  logic              qhPing,
  input  logic [LEN_W-1:0]  qhDataLen,
  input  logic              hsValid,
  input  logic              hsPing,
  input  logic              hsAck,
  input  logic              txStart,
  input  logic [TIME_W-1:0] txLen,
  input  logic [TIME_W-1:0] uframeLeft,
  input  logic              uframeTick,
  output logic [CNT_W-1:0]  bufCnt,
  output logic              bufFull,
  output logic              sleepDone,
  output logic              reclaim,
  output logic              curPing,
  output logic              curLenZero,
  output logic [LEN_W-1:0]  fetchLen,
  output logic              qhWbToOut,
  output logic              portStop
);

  localparam logic [LEN_W-1:0] MaxLen = LEN_W'(MAX_DATA_DW);
  localparam logic [SLP_W-1:0] SlpLoad = SLP_W'(SLEEP_CYCLES - 1);

  logic [SLP_W-1:0] sleepCnt;
  logic [LEN_W-1:0] curLen;

  assign bufFull    = (bufCnt == CNT_W'(DEPTH));
  assign sleepDone  = sleeping && (sleepCnt == '0);
  assign curLenZero = (curLen == '0);

  always_comb begin
    case (fetchType)
      FT_QH:   fetchLen = LEN_W'(QH_DW);
      FT_QTD:  fetchLen = LEN_W'(QTD_DW);
      default: fetchLen = curLen;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufCnt    <= '0;
      sleepCnt  <= '0;
      reclaim   <= 1'b0;
      curPing   <= 1'b0;
      curLen    <= '0;
      qhWbToOut <= 1'b0;
      portStop  <= 1'b0;
    end else begin
      case ({strb.commitTxn, hsValid})
        2'b10:   bufCnt <= bufCnt + 1'b1;
        2'b01:   if (bufCnt != '0) bufCnt <= bufCnt - 1'b1;
        default: ;
      endcase

      if (strb.startSleep)              sleepCnt <= SlpLoad;
      else if (sleeping && !sleepDone)  sleepCnt <= sleepCnt - 1'b1;

      if (hsValid)            reclaim <= 1'b1;
      else if (strb.passHead) reclaim <= 1'b0;

      if (strb.commitTxn) begin
        curPing <= qhPing;
        curLen  <= (qhDataLen > MaxLen) ? MaxLen : qhDataLen;
      end

      qhWbToOut <= hsValid && hsPing && hsAck;

      if (uframeTick)                         portStop <= 1'b0;
      else if (txStart && (txLen > uframeLeft)) portStop <= 1'b1;
    end
  end

endmodule

// File: rtl/async_fetch_ctrl.sv
module async_fetch_ctrl
  import afc_pkg::*;
#(
  parameter int unsigned DEPTH       = 2,
  parameter int unsigned CLK_MHZ     = 250,
  parameter int unsigned SLEEP_NS    = 10000,
  parameter int unsigned LEN_W       = 8,
  parameter int unsigned TIME_W      = 16,
  parameter int unsigned MAX_DATA_DW = 129,
  localparam int unsigned SLEEP_CYCLES = SLEEP_NS * CLK_MHZ / 1000,
  localparam int unsigned CNT_W        = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hcHalted,
  input  logic              asyncSchedOn,
  input  logic              busMasterEn,
  input  logic              qhValid,
  input  logic              qhHeadBit,
  input  logic              qhPing,
  input  logic [LEN_W-1:0]  qhDataLen,
  input  logic              fetchGrant,
  output logic              fetchReq,
  output logic [1:0]        fetchType,
  output logic [LEN_W-1:0]  fetchLen,
  input  logic              hsValid,
  input  logic              hsPing,
  input  logic              hsAck,
  output logic              qhWbToOut,
  input  logic              txStart,
  input  logic [TIME_W-1:0] txLen,
  input  logic [TIME_W-1:0] uframeLeft,
  input  logic              uframeTick,
  output logic              portStop,
  output logic              sleeping
);

  ctrlStrb_t        strb;
  fetch_t           fType;
  logic             gateOk, bufFull, sleepDone, reclaim, curPing, curLenZero;
  logic [CNT_W-1:0] bufCnt;

  assign gateOk    = !hcHalted && asyncSchedOn && busMasterEn;
  assign fetchType = fType;

  afc_ctrl u_ctrl (
    .clk, .rstN, .gateOk, .bufFull, .sleepDone, .reclaim, .curPing, .curLenZero,
    .qhValid, .qhHeadBit, .fetchGrant,
    .fetchReq, .fetchType(fType), .sleeping, .strb
  );

  afc_dpath #(
    .DEPTH(DEPTH), .SLEEP_CYCLES(SLEEP_CYCLES), .LEN_W(LEN_W),
    .TIME_W(TIME_W), .MAX_DATA_DW(MAX_DATA_DW)
  ) u_dpath (
    .clk, .rstN, .strb, .sleeping, .fetchType(fType), .qhPing, .qhDataLen,
    .hsValid, .hsPing, .hsAck, .txStart, .txLen, .uframeLeft, .uframeTick,
    .bufCnt, .bufFull, .sleepDone, .reclaim, .curPing, .curLenZero,
    .fetchLen, .qhWbToOut, .portStop
  );

endmodule

// File: rtl/afc_checker.sv
module afc_checker #(
  parameter int unsigned DEPTH       = 2,
  parameter int unsigned LEN_W       = 8,
  parameter int unsigned TIME_W      = 16,
  parameter int unsigned MAX_DATA_DW = 129,
  localparam int unsigned CNT_W      = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              hcHalted,
  input logic              asyncSchedOn,
  input logic              busMasterEn,
  input logic              sleeping,
  input logic              fetchReq,
  input logic [1:0]        fetchType,
  input logic [LEN_W-1:0]  fetchLen,
  input logic [CNT_W-1:0]  bufCnt,
  input logic              hsValid,
  input logic              hsPing,
  input logic              hsAck,
  input logic              qhWbToOut,
  input logic              txStart,
  input logic [TIME_W-1:0] txLen,
  input logic [TIME_W-1:0] uframeLeft,
  input logic              uframeTick,
  input logic              portStop
);

  AST_GATED_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |-> (!hcHalted && asyncSchedOn && busMasterEn && !sleeping)); // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    bufCnt <= CNT_W'(DEPTH)); // R5

  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && fetchType == 2'd0) |-> (bufCnt < CNT_W'(DEPTH))); // R5

  AST_QH_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && fetchType == 2'd0) |-> (fetchLen == LEN_W'(17))); // R9

  AST_QTD_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && fetchType == 2'd1) |-> (fetchLen == LEN_W'(13))); // R9

  AST_DATA_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && fetchType == 2'd2) |->
      (fetchLen != '0 && fetchLen <= LEN_W'(MAX_DATA_DW))); // R9

  AST_PING_WB: assert property (@(posedge clk) disable iff (!rstN)
    (hsValid && hsPing && hsAck) |=> qhWbToOut); // R7

  AST_LATE_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (txStart && (txLen > uframeLeft) && !uframeTick) |=> portStop); // R8

  AST_STOP_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    uframeTick |=> !portStop); // R8

endmodule

bind async_fetch_ctrl afc_checker #(
  .DEPTH(DEPTH), .LEN_W(LEN_W), .TIME_W(TIME_W), .MAX_DATA_DW(MAX_DATA_DW)
) u_chk (
  .clk, .rstN, .hcHalted, .asyncSchedOn, .busMasterEn, .sleeping,
  .fetchReq, .fetchType, .fetchLen, .bufCnt, .hsValid, .hsPing, .hsAck,
  .qhWbToOut, .txStart, .txLen, .uframeLeft, .uframeTick, .portStop
);

// File: tb/tb_async_fetch_ctrl.sv
`timescale 1ns/1ps
module tb_async_fetch_ctrl;

  localparam int SLEEP_EXP = 2500;
  localparam int SLEEP_TOL = 7;

  logic clk = 1'b0;
  logic rstN;
  logic hcHalted, asyncSchedOn, busMasterEn;
  logic qhValid, qhHeadBit, qhPing;
  logic [7:0] qhDataLen;
  logic fetchGrant, fetchReq;
  logic [1:0] fetchType;
  logic [7:0] fetchLen;
  logic hsValid, hsPing, hsAck, qhWbToOut;
  logic txStart, uframeTick, portStop, sleeping;
  logic [15:0] txLen, uframeLeft;

  int nChecks = 0;
  int nFails  = 0;
  int nSeen   = 0;
  logic [9:0] expQ[$];   // {type, len}
  bit done = 0;

  always #2 clk = ~clk;

  async_fetch_ctrl dut (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  // monitor: pop expected read on every accepted request
  always @(negedge clk) begin
    if (rstN && fetchReq && fetchGrant) begin
      nSeen++;
      if (expQ.size() == 0) begin
        check(0, "R10 unexpected read type", int'(fetchType), -1);
      end else begin
        logic [9:0] e;
        e = expQ.pop_front();
        check(fetchType == e[9:8], "R10 read type", int'(fetchType), int'(e[9:8]));
        check(fetchLen == e[7:0], "R9 read length", int'(fetchLen), int'(e[7:0]));
      end
    end
  end

  task automatic waitSeen(input int target, input string tag);
    for (int i = 0; i < 5000; i++) begin
      if (nSeen >= target) return;
      step();
    end
    check(0, tag, nSeen, target);
  endtask

  task automatic doTxn(input bit head, input bit ping, input int len, input bit expSleep);
    int base = nSeen;
    int n = 1;
    expQ.push_back({2'd0, 8'd17});
    fetchGrant = 1;
    waitSeen(base + 1, "R10 queue-head read missing");
    fetchGrant = 0;
    if (!expSleep) begin
      expQ.push_back({2'd1, 8'd13});
      n = 2;
      if (!ping && len != 0) begin
        expQ.push_back({2'd2, 8'((len > 129) ? 129 : len)});
        n = 3;
      end
    end
    qhHeadBit = head; qhPing = ping; qhDataLen = 8'(len); qhValid = 1;
    step();
    qhValid = 0;
    if (!expSleep) begin
      fetchGrant = 1;
      waitSeen(base + n, "R2 R6 descriptor sequence incomplete");
      fetchGrant = 0;
    end
  endtask

  task automatic handshake(input bit ping, input bit ack);
    hsValid = 1; hsPing = ping; hsAck = ack;
    step();
    hsValid = 0; hsPing = 0; hsAck = 0;
  endtask

  initial begin
    #200000;
    check(0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    int slept;
    rstN = 0; hcHalted = 1; asyncSchedOn = 1; busMasterEn = 1;
    qhValid = 0; qhHeadBit = 0; qhPing = 0; qhDataLen = 0; fetchGrant = 0;
    hsValid = 0; hsPing = 0; hsAck = 0;
    txStart = 0; txLen = 0; uframeLeft = 0; uframeTick = 0;
    repeat (3) step();
    check(fetchReq == 0, "R1 reset fetchReq", fetchReq, 0);
    check(sleeping == 0, "R3 reset sleeping", sleeping, 0);
    check(portStop == 0, "R8 reset portStop", portStop, 0);
    check(qhWbToOut == 0, "R7 reset qhWbToOut", qhWbToOut, 0);
    rstN = 1;
    step();

    // R1: each gate alone blocks issue
    check(fetchReq == 0, "R1 halted blocks", fetchReq, 0);
    hcHalted = 0; asyncSchedOn = 0; #1;
    check(fetchReq == 0, "R1 schedule off blocks", fetchReq, 0);
    asyncSchedOn = 1; busMasterEn = 0; #1;
    check(fetchReq == 0, "R1 bus master off blocks", fetchReq, 0);
    busMasterEn = 1; #1;
    check(fetchReq == 1, "R1 all gates open", fetchReq, 1);
    check(fetchType == 2'd0, "R10 first read is queue head", fetchType, 0);
    busMasterEn = 0; step();
    check(fetchReq == 0, "R1 withdrawn request", fetchReq, 0);
    busMasterEn = 1; step();

    // R10 R9 normal transaction, R6 ping transaction
    doTxn(0, 0, 40, 0);
    doTxn(0, 1, 40, 0);

    // R5 both entries taken: stall
    repeat (3) step();
    check(fetchReq == 0, "R5 stall when full", fetchReq, 0);

    // R7 ping acknowledged, R5 entry freed, R4 reclamation set
    handshake(1, 1);
    check(qhWbToOut == 1, "R7 write-back pulse", qhWbToOut, 1);
    check(fetchReq == 1, "R5 freed entry resumes", fetchReq, 1);
    step();
    check(qhWbToOut == 0, "R7 pulse one cycle", qhWbToOut, 0);

    // R2 R4 head with reclamation set continues; R9 clamp to 129
    doTxn(1, 0, 200, 0);
    handshake(0, 0);
    check(qhWbToOut == 0, "R7 no write-back without ping", qhWbToOut, 0);
    handshake(0, 1);
    check(qhWbToOut == 0, "R7 no write-back for non-ping ack", qhWbToOut, 0);

    // R9 zero payload skips data; R2 head with reclamation set
    doTxn(1, 0, 0, 0);

    // R2 head with reclamation clear: sleep; R3 duration
    doTxn(1, 0, 50, 1);
    check(sleeping == 1, "R2 sleep entered", sleeping, 1);
    check(fetchReq == 0, "R1 no read while sleeping", fetchReq, 0);
    slept = 0;
    while (sleeping && slept < 10000) begin
      slept++;
      step();
    end
    check((slept >= SLEEP_EXP - SLEEP_TOL) && (slept <= SLEEP_EXP + SLEEP_TOL),
          "R3 sleep length", slept, SLEEP_EXP);
    check(fetchReq == 1 && fetchType == 2'd0, "R3 resume with queue head",
          int'(fetchType), 0);
    expQ.push_back({2'd0, 8'd17});
    fetchGrant = 1;
    waitSeen(nSeen + 1, "R3 resume read missing");
    fetchGrant = 0;

    // R8 late start
    txLen = 16'd10; uframeLeft = 16'd50; txStart = 1; step(); txStart = 0;
    check(portStop == 0, "R8 fitting packet", portStop, 0);
    txLen = 16'd100; txStart = 1; step(); txStart = 0;
    check(portStop == 1, "R8 late packet stops ports", portStop, 1);
    txLen = 16'd10; txStart = 1; step(); txStart = 0;
    step();
    check(portStop == 1, "R8 stop held to microframe end", portStop, 1);
    uframeTick = 1; step(); uframeTick = 0;
    check(portStop == 0, "R8 cleared on new microframe", portStop, 0);

    check(expQ.size() == 0, "R10 leftover expected reads", expQ.size(), 0);
    finishRun();
  end

endmodule